// File: doc/BRIEF.md
# Float-to-Int32 Truncating Converter

This block turns an already unpacked floating-point operand into a signed 32-bit integer. The operand arrives as four fields: a class code (zero, finite number, infinity, NaN), a sign, a signed unbiased exponent, and a mantissa whose leading one is at the top bit. The value of a finite number is `mant * 2^(exp - (MANT_W-1))`.

Conversion always truncates toward zero, whatever rounding mode the surrounding unit uses. Two exception flags come out with the result. The inexact flag reports that fraction bits were thrown away. The invalid flag reports that the value cannot be represented. Saturation is asymmetric. A negative value whose magnitude is exactly 2^31 converts cleanly to the most negative integer. Positive values of that size, and every larger magnitude, saturate.

The datapath is combinational. It feeds one output register stage with a valid bit, so each accepted operand produces exactly one result one cycle later.

Top module: `fp2i_trunc_conv`

## Requirements
- R1: After reset `out_valid` is 0, `out_int` is 0, and both flags are 0.
- R2: `out_valid` equals `in_valid` of the previous cycle, and the result for an accepted operand appears in that same next cycle.
- R3: Class code 0 (zero) gives `out_int` = 0 with both flags clear, whatever the sign, exponent and mantissa.
- R4: For class code 1 (number) with exponent 0 to 31, the result is the integer part of the value, truncated toward zero. `out_inexact` is 1 exactly when any discarded fraction bit is nonzero.
- R5: For class code 1 with a negative exponent, the result is 0 and `out_inexact` is 1 whenever the mantissa is nonzero.
- R6: A sign of 1 on a result that does not overflow yields the two's complement of the truncated magnitude.
- R7: For class code 1 with an exponent of 32 or more, the operand is treated as an overflow.
- R8: A truncated magnitude of at least 2^31 overflows when the sign is 0. With the sign at 1, a magnitude of exactly 2^31 gives 0x80000000 with `out_invalid` clear, and anything larger overflows.
- R9: Class codes 2 (infinity) and 3 (NaN) are treated as an overflow, regardless of the other fields.
- R10: On overflow, `out_int` is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1, `out_invalid` is 1 and `out_inexact` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_cls | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | INT_W | Truncated signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The block has only one register stage. Any fault in the shift amount, the sticky collection, the overflow decision or the negation therefore shows up at the ports in the cycle right after the operand is accepted, as a wrong integer or a wrong flag. The reference model compares every cycle, so each fault is pinned to the operand that caused it. Operands are chosen to sit on the decision edges: exponents of -1, 0, 31 and 32, magnitudes of 2^31 and 2^31+1 under both signs, and single lost bits at the bottom of the fraction. A sticky or comparison error cannot hide behind an operand that happens to be easy.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;
   typedef enum logic [1:0] {
      FCLS_ZERO = 2'd0,
      FCLS_NUM  = 2'd1,
      FCLS_INF  = 2'd2,
      FCLS_NAN  = 2'd3
   } fcls_e;
endpackage

// File: rtl/fp2i_rshift_sticky.sv
// Logarithmic right shifter that also ORs together every bit shifted out.
module fp2i_rshift_sticky #(
   parameter int W    = 64,
   parameter int SH_W = 7
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] sh,
   output logic [W-1:0]    dout,
   output logic            lost
);
   logic [SH_W:0][W-1:0] stg;
   logic [SH_W-1:0]      lost_v;

   assign stg[0] = din;

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      if (STEP < W) begin : g_part
         assign stg[k+1]  = sh[k] ? (stg[k] >> STEP) : stg[k];
         assign lost_v[k] = sh[k] & (|stg[k][STEP-1:0]);
      end else begin : g_full
         assign stg[k+1]  = sh[k] ? '0 : stg[k];
         assign lost_v[k] = sh[k] & (|stg[k]);
      end
   end

   assign dout = stg[SH_W];
   assign lost = |lost_v;
endmodule

// File: rtl/fp2i_sat.sv
// Overflow decision, saturation and sign application.
module fp2i_sat #(
   parameter int INT_W = 32,
   parameter int MAG_W = 64
) (
   input  logic             is_zero,
   input  logic             force_ovf,
   input  logic             sign,
   input  logic [MAG_W-1:0] mag,
   input  logic             lost,
   output logic [INT_W-1:0] res,
   output logic             inexact,
   output logic             invalid
);
   localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

   logic             hi_nz;
   logic [INT_W-1:0] lo;
   logic             mag_ovf;
   logic             ovf;

   if (MAG_W > INT_W) begin : g_wide
      assign hi_nz = |mag[MAG_W-1:INT_W];
   end else begin : g_exact
      assign hi_nz = 1'b0;
   end

   assign lo      = mag[INT_W-1:0];
   // 2^(INT_W-1) is legal only for negative results.
   assign mag_ovf = hi_nz | (lo[INT_W-1] & (~sign | (|lo[INT_W-2:0])));
   assign ovf     = force_ovf | mag_ovf;

   always_comb begin
      res     = '0;
      inexact = 1'b0;
      invalid = 1'b0;
      if (is_zero) begin
         res = '0;
      end else if (ovf) begin
         res     = sign ? NEG_LIM : POS_LIM;
         invalid = 1'b1;
      end else begin
         res     = sign ? (~lo + 1'b1) : lo;
         inexact = lost;
      end
   end
endmodule

// File: rtl/fp2i_outreg.sv
// Output register stage with valid bit.
module fp2i_outreg #(
   parameter int INT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  logic [INT_W-1:0] d_int,
   input  logic             d_inexact,
   input  logic             d_invalid,
   output logic             q_valid,
   output logic [INT_W-1:0] q_int,
   output logic             q_inexact,
   output logic             q_invalid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_int     <= '0;
         q_inexact <= 1'b0;
         q_invalid <= 1'b0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) begin
            q_int     <= d_int;
            q_inexact <= d_inexact;
            q_invalid <= d_invalid;
         end
      end
   end
endmodule

// File: rtl/fp2i_trunc_conv.sv
module fp2i_trunc_conv
   import fp2i_pkg::*;
#(
   parameter int MANT_W = 64,
   parameter int EXP_W  = 16,
   parameter int INT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_cls,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   output logic              out_valid,
   output logic [INT_W-1:0]  out_int,
   output logic              out_inexact,
   output logic              out_invalid
);
   localparam int SH_W = $clog2(MANT_W + 1);
   localparam logic signed [EXP_W:0] EXP_LIM = $signed((EXP_W+1)'(INT_W));
   localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

   if (INT_W < 2) begin : g_bad_int
      $error("INT_W must be at least 2");
   end
   if (MANT_W < INT_W) begin : g_bad_mant
      $error("MANT_W must be at least INT_W");
   end
   if (EXP_W < $clog2(INT_W) + 2) begin : g_bad_exp
      $error("EXP_W too narrow to express INT_W");
   end

   fcls_e                   cls;
   logic signed [EXP_W:0]   exp_s;
   logic                    exp_neg;
   logic                    exp_big;
   logic [SH_W-1:0]         sh_amt;
   logic [MANT_W-1:0]       shifted;
   logic                    lost;
   logic                    is_zero;
   logic                    force_ovf;
   logic [INT_W-1:0]        c_int;
   logic                    c_inexact;
   logic                    c_invalid;

   assign cls     = fcls_e'(in_cls);
   assign exp_s   = $signed({in_exp[EXP_W-1], in_exp});
   assign exp_neg = in_exp[EXP_W-1];
   assign exp_big = (exp_s >= EXP_LIM);
   // Negative exponents shift the whole mantissa out.
   assign sh_amt  = exp_neg ? SH_W'(MANT_W)
                            : SH_W'(MANT_W - 1) - SH_W'(in_exp);

   assign is_zero   = (cls == FCLS_ZERO);
   assign force_ovf = (cls == FCLS_INF) || (cls == FCLS_NAN) ||
                      ((cls == FCLS_NUM) && exp_big);

   fp2i_rshift_sticky #(.W(MANT_W), .SH_W(SH_W)) u_shift (
      .din  (in_mant),
      .sh   (sh_amt),
      .dout (shifted),
      .lost (lost)
   );

   fp2i_sat #(.INT_W(INT_W), .MAG_W(MANT_W)) u_sat (
      .is_zero   (is_zero),
      .force_ovf (force_ovf),
      .sign      (in_sign),
      .mag       (shifted),
      .lost      (lost),
      .res       (c_int),
      .inexact   (c_inexact),
      .invalid   (c_invalid)
   );

   fp2i_outreg #(.INT_W(INT_W)) u_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_valid   (in_valid),
      .d_int     (c_int),
      .d_inexact (c_inexact),
      .d_invalid (c_invalid),
      .q_valid   (out_valid),
      .q_int     (out_int),
      .q_inexact (out_inexact),
      .q_invalid (out_invalid)
   );

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 2'd0) |=> (out_int == '0 && !out_inexact && !out_invalid)); // R3
   AST_NEG_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 2'd1 && in_exp[EXP_W-1]) |=> (out_int == '0 && !out_invalid)); // R5
   AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 2'd1 && exp_big) |=> out_invalid); // R7
   AST_NONNUM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls[1]) |=> out_invalid); // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_inexact && out_invalid)); // R10
   AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_int == POS_LIM || out_int == NEG_LIM)); // R10
endmodule

// File: tb/fp2i_trunc_conv_tb.sv
module fp2i_trunc_conv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_cls = 2'd0;
   logic        in_sign = 1'b0;
   logic [15:0] in_exp = '0;
   logic [63:0] in_mant = '0;
   logic        out_valid;
   logic [31:0] out_int;
   logic        out_inexact;
   logic        out_invalid;

   int checks = 0;
   int fails  = 0;

   logic        pend_valid = 1'b0;
   logic [33:0] pend_res = '0;
   string       pend_tag = "R2";

   always #5 clk = ~clk;

   fp2i_trunc_conv u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
      .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
      .out_valid(out_valid), .out_int(out_int),
      .out_inexact(out_inexact), .out_invalid(out_invalid)
   );

   // Result packed as {inexact, invalid, int}.
   function automatic logic [33:0] ref_conv(logic [1:0] c, logic s, int e, logic [63:0] m);
      longint unsigned mag;
      logic            lst;
      int              sh;
      logic [31:0]     r;
      if (c == 2'd0) return 34'd0;
      if (c >= 2'd2 || e >= 32)
         return {1'b0, 1'b1, (s ? 32'h8000_0000 : 32'h7FFF_FFFF)};
      sh = 63 - e;
      if (sh >= 64) begin
         mag = 0;
         lst = (m != 0);
      end else begin
         mag = m >> sh;
         lst = ((m & ((64'd1 << sh) - 64'd1)) != 0);
      end
      if (mag >= 64'h8000_0000 + longint'(s))
         return {1'b0, 1'b1, (s ? 32'h8000_0000 : 32'h7FFF_FFFF)};
      r = s ? 32'(64'd0 - mag) : 32'(mag);
      return {lst, 1'b0, r};
   endfunction

   task automatic check_pending();
      checks++;
      if (out_valid !== pend_valid) begin
         fails++;
         $display("FAIL R2 out_valid: actual %b expected %b", out_valid, pend_valid);
      end
      if (pend_valid) begin
         checks++;
         if ({out_inexact, out_invalid, out_int} !== pend_res) begin
            fails++;
            $display("FAIL %s: actual inx=%b inv=%b int=%h expected inx=%b inv=%b int=%h",
                     pend_tag, out_inexact, out_invalid, out_int,
                     pend_res[33], pend_res[32], pend_res[31:0]);
         end
      end
   endtask

   task automatic step(input logic v, input logic [1:0] c, input logic s,
                       input int e, input logic [63:0] m, input string tag);
      @(negedge clk);
      check_pending();
      in_valid   = v;
      in_cls     = c;
      in_sign    = s;
      in_exp     = 16'(e);
      in_mant    = m;
      pend_valid = v;
      pend_res   = ref_conv(c, s, e, m);
      pend_tag   = tag;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual no completion expected completion");
      finish_run();
   end

   localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_int !== 32'd0 || out_inexact !== 1'b0 || out_invalid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: actual v=%b int=%h inx=%b inv=%b expected all zero",
                  out_valid, out_int, out_inexact, out_invalid);
      end
      rst_n = 1'b1;

      // R3 zero class, odd other fields
      step(1, 2'd0, 0, 5, ONE, "R3");
      step(1, 2'd0, 1, 100, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      // R4 exact and inexact truncation
      step(1, 2'd1, 0, 0, ONE, "R4");
      step(1, 2'd1, 0, 10, 64'hC000_0000_0000_0001, "R4");
      step(1, 2'd1, 0, 30, 64'hFFFF_FFFE_0000_0000, "R4");
      step(1, 2'd1, 0, 30, 64'hFFFF_FFFE_0000_0001, "R4");
      step(1, 2'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
      // R2 idle gap
      step(0, 2'd1, 0, 3, ONE, "R2");
      step(0, 2'd0, 0, 0, 0, "R2");
      // R5 negative exponents
      step(1, 2'd1, 0, -1, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
      step(1, 2'd1, 1, -100, ONE, "R5");
      // R6 negative results
      step(1, 2'd1, 1, 5, 64'hC000_0000_0000_0000, "R6");
      step(1, 2'd1, 1, 0, 64'hC000_0000_0000_0000, "R6");
      step(1, 2'd1, 1, 20, 64'hABCD_1234_5678_9ABC, "R6");
      // R7 large exponent
      step(1, 2'd1, 0, 32, ONE, "R7");
      step(1, 2'd1, 1, 40, ONE, "R7");
      step(1, 2'd1, 0, 1000, ONE, "R7");
      // R8 the 2^31 edge
      step(1, 2'd1, 0, 31, ONE, "R8");
      step(1, 2'd1, 1, 31, ONE, "R8");
      step(1, 2'd1, 1, 31, ONE | 64'd1, "R8");
      step(1, 2'd1, 1, 31, ONE | 64'h1_0000_0000, "R8");
      step(1, 2'd1, 0, 30, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
      // R9 / R10 non-numbers
      step(1, 2'd2, 0, 0, 0, "R9");
      step(1, 2'd2, 1, 0, 0, "R9");
      step(1, 2'd3, 0, -5, 64'h1234, "R10");
      step(1, 2'd3, 1, 12, ONE, "R10");

      for (int i = 0; i < 400; i++) begin
         logic [1:0] c;
         int         e;
         c = ($urandom % 8 < 6) ? 2'd1 : 2'($urandom % 4);
         e = int'($urandom_range(0, 80)) - 40;
         step(($urandom % 5) != 0, c, 1'($urandom), e,
              {$urandom, $urandom} | ONE, "R4");
      end
      step(0, 2'd0, 0, 0, 0, "R2");
      step(0, 2'd0, 0, 0, 0, "R2");
      finish_run();
   end
endmodule